// File: doc/BRIEF.md
# Configurable SPI Master Transceiver

This block is a full-duplex SPI master. Writing a word to its data port queues it for transmission; the block then asserts an active-low slave select, clocks the word out on MOSI while clocking a word in from MISO, and releases the select. Clock polarity, clock phase, bit order and an 8-bit or 16-bit frame width are chosen by configuration inputs. These inputs are held steady while the block is busy. The serial clock half-period is `cfg_div + 1` system clocks.

Received bits collect in a private shift register. They are copied to the readable data register only when the last bit of a frame is in. The same event raises a completion flag. Software clears the flag by reading status and then reading data. A frame that completes while the flag is still up sets an overrun bit and is discarded. The slave select is framed by three delays: a leading delay, a trailing delay and an idle delay, each a count of SCK half-periods. A word written while a frame is running waits in a one-entry buffer and goes out back-to-back: the select stays low and the leading and idle delays are skipped.

Top module: `spim_master`

## Requirements
- R1: A frame exchanges one word each way. Afterwards `rd_data` holds the word the slave sent, and the slave holds the word written. With `cfg_wide`=0 the frame is 8 bits and `rd_data[15:8]` reads 0; with `cfg_wide`=1 it is 16 bits.
- R2: With `cfg_lsb_first`=0 bits travel most significant first; with 1 least significant first. The same order applies to both directions.
- R3: With `cfg_cpha`=1 MOSI changes on odd SCK edges and MISO is sampled on even edges. With `cfg_cpha`=0 the first bit is on MOSI when select asserts and sampling is on odd edges. Edges are counted 1..2n within a frame.
- R4: Whenever the select is high, `sck` sits at the level `cfg_cpol`.
- R5: A frame of n bits has exactly 2n SCK edges, spaced `cfg_div+1` clocks apart.
- R6: `ss_n` falls `L*(cfg_div+1)` clocks before the first edge, where L is `cfg_lead` (0 counts as 1).
- R7: `ss_n` rises `T*(cfg_div+1)` clocks after the last edge, where T is `cfg_trail` (0 counts as 1).
- R8: If a word is waiting when the select rises, `ss_n` stays high for `I*(cfg_div+1)+1` clocks, where I is `cfg_idle` (0 counts as 1).
- R9: A word written during a frame is sent back-to-back. `ss_n` stays low, and the next first edge comes `(T+1)*(cfg_div+1)` clocks after the previous last edge.
- R10: A write while the one-entry buffer already holds a word is ignored.
- R11: `xfer_done` rises when a frame completes. A data read clears it only after a status read has seen it set; a data read alone leaves it set.
- R12: If a frame completes while `xfer_done` is set, `overrun` goes to 1 and `rd_data` keeps the older word. The clearing sequence also clears `overrun`.
- R13: `rd_data` does not change while a frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | Clock phase: 1 samples on even edges |
| cfg_lsb_first | input | 1 | 1 sends least significant bit first |
| cfg_wide | input | 1 | 0 selects 8-bit frames, 1 selects 16-bit frames |
| cfg_div | input | 8 | SCK half-period minus one, in clocks |
| cfg_lead | input | 4 | Select-to-first-edge delay, in half-periods |
| cfg_trail | input | 4 | Last-edge-to-release delay, in half-periods |
| cfg_idle | input | 4 | Minimum select-high time, in half-periods |
| wr_en | input | 1 | Write strobe for the transmit word |
| wr_data | input | 16 | Transmit word |
| rd_stat | input | 1 | Status read strobe |
| rd_data_en | input | 1 | Data read strobe |
| rd_data | output | 16 | Last received word |
| xfer_done | output | 1 | Completion flag |
| overrun | output | 1 | A completed frame was dropped |
| busy | output | 1 | A frame is running or a word is waiting |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
The hardest case to reach is a back-to-back chain that also has a full buffer. The bench writes a second word only after the first has left the buffer, then a third while the second still waits. It must then read the first result in the middle of the second frame to stay clear of overrun. The idle gap is only measurable when a word is waiting at the instant the select rises. So the bench watches for that rise and writes in the same cycle, which lands the word during the idle count.

// File: rtl/spim_pkg.sv
package spim_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_XFER,
        ST_TRAIL,
        ST_GAP
    } spim_state_e;
endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick = run && (cnt_q == div);
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt_q <= div);
endmodule

// File: rtl/spim_txbuf.sv
module spim_txbuf #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] data
);
    typedef struct packed {
        logic         full;
        logic [W-1:0] data;
    } buf_t;

    buf_t d, q;

    always_comb begin
        d = q;
        if (take) d.full = 1'b0;
        if (wr_en && !q.full) begin
            d.full = 1'b1;
            d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign full = q.full;
    assign data = q.data;

    // R10
    wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.full && wr_en) |=> $stable(q.data));
endmodule

// File: rtl/spim_stat.sv
module spim_stat #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         done,
    input  logic [W-1:0] rx_word,
    input  logic         rd_stat,
    input  logic         rd_data_en,
    output logic         flag,
    output logic         ovr,
    output logic [W-1:0] data
);
    typedef struct packed {
        logic         flag;
        logic         ovr;
        logic         armed;
        logic [W-1:0] data;
    } stat_t;

    stat_t d, q;
    logic  clr;

    always_comb begin
        d   = q;
        clr = rd_data_en && q.armed;
        if (rd_stat && q.flag) d.armed = 1'b1;
        if (clr) begin
            d.flag  = 1'b0;
            d.ovr   = 1'b0;
            d.armed = 1'b0;
        end
        if (done) begin
            if (q.flag && !clr) begin
                d.ovr = 1'b1;
            end else begin
                d.flag  = 1'b1;
                d.armed = 1'b0;
                d.data  = rx_word;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flag = q.flag;
    assign ovr  = q.ovr;
    assign data = q.data;

    // R12
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ovr) |-> $past(q.flag));
    // R11
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.flag) |-> $past(rd_data_en && q.armed));
    // R13
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.data) |-> $past(done));
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int W     = 16,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cpha,
    input  logic             lsb_first,
    input  logic             wide,
    input  logic [DLY_W-1:0] lead,
    input  logic [DLY_W-1:0] trail,
    input  logic [DLY_W-1:0] idle,
    input  logic             buf_full,
    input  logic [W-1:0]     buf_data,
    input  logic             miso,
    output logic             run,
    output logic             take,
    output logic             done,
    output logic [W-1:0]     rx_word,
    output logic             sck_raw,
    output logic             mosi,
    output logic             ss_n
);
    localparam int HALF   = W / 2;
    localparam int EDGE_W = $clog2(2 * W + 1);

    typedef struct packed {
        spim_state_e       st;
        logic [DLY_W-1:0]  cnt;
        logic [EDGE_W-1:0] edge_n;
        logic [W-1:0]      tx;
        logic [W-1:0]      rx;
        logic              sck;
        logic              ss_n;
    } ctrl_t;

    ctrl_t d, q;
    logic [EDGE_W-1:0] nedges, edge_nx;
    logic              samp;
    logic [W-1:0]      rx_sh, tx_sh;

    always_comb begin
        nedges  = wide ? EDGE_W'(2 * W) : EDGE_W'(W);
        edge_nx = q.edge_n + 1'b1;
        samp    = cpha ? !edge_nx[0] : edge_nx[0];
        if (!lsb_first)  rx_sh = {q.rx[W-2:0], miso};
        else if (wide)   rx_sh = {miso, q.rx[W-1:1]};
        else             rx_sh = {{HALF{1'b0}}, miso, q.rx[HALF-1:1]};
        tx_sh   = lsb_first ? (q.tx >> 1) : (q.tx << 1);
        rx_word = samp ? rx_sh : q.rx;
        mosi    = lsb_first ? q.tx[0] : (wide ? q.tx[W-1] : q.tx[HALF-1]);
        run     = (q.st != ST_IDLE);

        d    = q;
        take = 1'b0;
        done = 1'b0;
        unique case (q.st)
            ST_IDLE: if (buf_full) begin
                d.tx = buf_data; d.rx = '0; d.edge_n = '0; take = 1'b1;
                d.ss_n = 1'b0;
                if (lead <= DLY_W'(1)) d.st = ST_XFER;
                else begin
                    d.st  = ST_LEAD;
                    d.cnt = lead - 1'b1;
                end
            end
            ST_LEAD: if (tick) begin
                if (q.cnt <= DLY_W'(1)) d.st = ST_XFER;
                else                    d.cnt = q.cnt - 1'b1;
            end
            ST_XFER: if (tick) begin
                d.sck    = ~q.sck;
                d.edge_n = edge_nx;
                if (samp)                     d.rx = rx_sh;
                else if (edge_nx > EDGE_W'(1)) d.tx = tx_sh;
                if (edge_nx == nedges) begin
                    done  = 1'b1;
                    d.st  = ST_TRAIL;
                    d.cnt = trail;
                end
            end
            ST_TRAIL: if (tick) begin
                if (q.cnt <= DLY_W'(1)) begin
                    if (buf_full) begin
                        d.tx = buf_data; d.rx = '0; d.edge_n = '0; take = 1'b1;
                        d.st = ST_XFER;
                    end else begin
                        d.ss_n = 1'b1;
                        d.st   = ST_GAP;
                        d.cnt  = idle;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_GAP: if (tick) begin
                if (q.cnt <= DLY_W'(1)) d.st = ST_IDLE;
                else                    d.cnt = q.cnt - 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.ss_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sck_raw = q.sck;
    assign ss_n    = q.ss_n;

    // R4
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.ss_n |-> !q.sck);
    // R5
    edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_XFER) |-> (q.edge_n < nedges));
    // R9
    select_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_XFER) |-> !q.ss_n);
endmodule

// File: rtl/spim_master.sv
module spim_master #(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8,
    parameter int DLY_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_lsb_first,
    input  logic              cfg_wide,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [DLY_W-1:0]  cfg_lead,
    input  logic [DLY_W-1:0]  cfg_trail,
    input  logic [DLY_W-1:0]  cfg_idle,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stat,
    input  logic              rd_data_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              xfer_done,
    output logic              overrun,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              ss_n
);
    logic              tick, run, take, done, sck_raw, buf_full;
    logic [DATA_W-1:0] buf_data, rx_word;

    spim_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .div(cfg_div), .tick(tick)
    );

    spim_txbuf #(.W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .take(take), .full(buf_full), .data(buf_data)
    );

    spim_ctrl #(.W(DATA_W), .DLY_W(DLY_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cpha(cfg_cpha),
        .lsb_first(cfg_lsb_first), .wide(cfg_wide), .lead(cfg_lead),
        .trail(cfg_trail), .idle(cfg_idle), .buf_full(buf_full),
        .buf_data(buf_data), .miso(miso), .run(run), .take(take),
        .done(done), .rx_word(rx_word), .sck_raw(sck_raw), .mosi(mosi),
        .ss_n(ss_n)
    );

    spim_stat #(.W(DATA_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .done(done), .rx_word(rx_word),
        .rd_stat(rd_stat), .rd_data_en(rd_data_en), .flag(xfer_done),
        .ovr(overrun), .data(rd_data)
    );

    assign sck  = sck_raw ^ cfg_cpol;
    assign busy = run || buf_full;
endmodule

// File: tb/spim_master_bench.sv
module spim_master_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_cpol = 0, cfg_cpha = 0, cfg_lsb_first = 0, cfg_wide = 0;
    logic [7:0]  cfg_div = 8'd1;
    logic [3:0]  cfg_lead = 4'd1, cfg_trail = 4'd1, cfg_idle = 4'd2;
    logic        wr_en = 0, rd_stat = 0, rd_data_en = 0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        xfer_done, overrun, busy, sck, mosi, ss_n;
    logic        miso = 1'b0;

    int checks = 0, errors = 0, cyc = 0;

    spim_master u_spim_master (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_lsb_first(cfg_lsb_first), .cfg_wide(cfg_wide), .cfg_div(cfg_div),
        .cfg_lead(cfg_lead), .cfg_trail(cfg_trail), .cfg_idle(cfg_idle),
        .wr_en(wr_en), .wr_data(wr_data), .rd_stat(rd_stat),
        .rd_data_en(rd_data_en), .rd_data(rd_data), .xfer_done(xfer_done),
        .overrun(overrun), .busy(busy), .sck(sck), .mosi(mosi), .miso(miso),
        .ss_n(ss_n)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard queues
    logic [15:0] sl_tx_q[$];
    logic [15:0] exp_sl_q[$];
    logic [15:0] exp_m_q[$];

    function automatic int eff(logic [3:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction
    function automatic int nbits();
        return cfg_wide ? 16 : 8;
    endfunction
    function automatic int bpos(int i);
        return cfg_lsb_first ? i : nbits() - 1 - i;
    endfunction
    function automatic logic [15:0] msk(logic [15:0] w);
        return cfg_wide ? w : {8'h00, w[7:0]};
    endfunction

    // slave model and timing monitor
    logic        ss_prev = 1'b1, sck_prev = 1'b0, b2b = 1'b0, chk_idle = 1'b0;
    logic        bad_per = 1'b0;
    logic [15:0] sl_word = '0, sl_rx = '0;
    int k = 0, fall_cyc = 0, rise_cyc = 0, last_edge = 0, prev_edge = 0;
    int frames = 0, rises = 0, b2b_cnt = 0;

    task automatic peek_drive();
        sl_word = (sl_tx_q.size() > 0) ? sl_tx_q[0] : 16'h0;
        if (!cfg_cpha) miso = sl_word[bpos(0)];
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (ss_prev && !ss_n) begin
                fall_cyc = cyc; b2b = 1'b0; k = 0;
                chk("R4 sck idle at select", int'(sck), int'(cfg_cpol));
                if (chk_idle) begin
                    chk("R8 idle gap", cyc - rise_cyc,
                        eff(cfg_idle) * (int'(cfg_div) + 1) + 1);
                    chk_idle = 1'b0;
                end
                peek_drive();
            end
            if (!ss_prev && ss_n) begin
                rise_cyc = cyc; rises++;
                chk("R7 trail", cyc - last_edge, eff(cfg_trail) * (int'(cfg_div) + 1));
                chk("R5 whole frame", k, 0);
                chk("R4 sck idle at release", int'(sck), int'(cfg_cpol));
            end
            if (sck != sck_prev && !ss_n) begin
                k++;
                if (k == 1) begin
                    sl_word = (sl_tx_q.size() > 0) ? sl_tx_q.pop_front() : 16'h0;
                    sl_rx = '0; bad_per = 1'b0;
                    if (b2b) begin
                        chk("R9 back-to-back gap", cyc - last_edge,
                            (eff(cfg_trail) + 1) * (int'(cfg_div) + 1));
                        b2b_cnt++;
                    end else begin
                        chk("R6 lead", cyc - fall_cyc, eff(cfg_lead) * (int'(cfg_div) + 1));
                    end
                end else if (cyc - prev_edge != int'(cfg_div) + 1) begin
                    bad_per = 1'b1;
                end
                prev_edge = cyc;
                if (cfg_cpha ? (k % 2 == 0) : (k % 2 == 1))
                    sl_rx[bpos((k - 1) / 2)] = mosi;
                else if (cfg_cpha)
                    miso = sl_word[bpos((k - 1) / 2)];
                else if (k < 2 * nbits())
                    miso = sl_word[bpos(k / 2)];
                if (k == 2 * nbits()) begin
                    chk("R5 edge spacing", int'(bad_per), 0);
                    if (exp_sl_q.size() > 0)
                        chk("R1/R2/R3 slave received", sl_rx, exp_sl_q.pop_front());
                    else
                        chk("R10 unexpected frame", 1, 0);
                    frames++;
                    last_edge = cyc; k = 0; b2b = 1'b1;
                    peek_drive();
                end
            end
            ss_prev  = ss_n;
            sck_prev = sck;
        end
    end

    task automatic setup(logic pol, logic pha, logic lsb, logic wd,
                         logic [7:0] dv, logic [3:0] ld, logic [3:0] tr, logic [3:0] idl);
        while (busy) @(negedge clk);
        cfg_cpol = pol; cfg_cpha = pha; cfg_lsb_first = lsb; cfg_wide = wd;
        cfg_div = dv; cfg_lead = ld; cfg_trail = tr; cfg_idle = idl;
        @(negedge clk);
    endtask

    task automatic raw_write(logic [15:0] w);
        wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send(logic [15:0] mw, logic [15:0] sw);
        sl_tx_q.push_back(sw);
        exp_sl_q.push_back(msk(mw));
        exp_m_q.push_back(msk(sw));
        raw_write(mw);
    endtask

    task automatic collect(string tag);
        logic [15:0] e;
        while (xfer_done !== 1'b1) @(negedge clk);
        e = exp_m_q.pop_front();
        rd_stat = 1'b1;
        @(negedge clk);
        rd_stat = 1'b0; rd_data_en = 1'b1;
        chk(tag, rd_data, e);
        @(negedge clk);
        rd_data_en = 1'b0;
        chk("R11 flag cleared", int'(xfer_done), 0);
    endtask

    initial begin : watchdog
        while (cyc < 150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        int f0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4 reset ss_n", int'(ss_n), 1);
        chk("R4 reset sck", int'(sck), 0);
        chk("R11 reset flag", int'(xfer_done), 0);
        chk("R12 reset overrun", int'(overrun), 0);

        // R1 R3: phase 0, 8-bit, MSB first, lead 0 counts as one
        setup(0, 0, 0, 0, 8'd1, 4'd0, 4'd1, 4'd2);
        send(16'h12A5, 16'h003C);
        collect("R1 8-bit upper byte zero");
        // R3 R4: phase 1, polarity 1, 16-bit
        setup(1, 1, 0, 1, 8'd2, 4'd3, 4'd2, 4'd2);
        send(16'hBEEF, 16'h1234);
        collect("R3 phase1 16-bit rx");
        // R2: LSB first, both widths and phases
        setup(0, 1, 1, 0, 8'd0, 4'd2, 4'd3, 4'd1);
        send(16'h0081, 16'h00C6);
        collect("R2 lsb first 8-bit rx");
        setup(1, 0, 1, 1, 8'd3, 4'd1, 4'd1, 4'd1);
        send(16'h8001, 16'hF00D);
        collect("R2 lsb first 16-bit rx");

        // R13: data register steady during a frame
        setup(0, 1, 0, 1, 8'd2, 4'd1, 4'd1, 4'd1);
        send(16'h5555, 16'hA0A0);
        collect("R1 16-bit rx");
        send(16'h0F0F, 16'h7E81);
        while (k < 10) @(negedge clk);
        chk("R13 data held mid-frame", rd_data, 16'hA0A0);
        collect("R13 data after frame");

        // R8: word waiting when select rises
        setup(0, 0, 0, 0, 8'd3, 4'd2, 4'd1, 4'd3);
        send(16'h0011, 16'h0022);
        collect("R1 first of pair");
        while (!ss_n) @(negedge clk);
        chk_idle = 1'b1;
        send(16'h0033, 16'h0044);
        collect("R8 second of pair");
        chk("R8 idle measured", int'(chk_idle), 0);

        // R9 R10: back-to-back with a dropped third write
        setup(1, 1, 0, 0, 8'd2, 4'd2, 4'd1, 4'd2);
        f0 = rises; b2b_cnt = 0;
        send(16'h00A1, 16'h00B1);
        repeat (3) @(negedge clk);
        send(16'h00A2, 16'h00B2);
        raw_write(16'h00FF);
        collect("R9 first frame");
        collect("R9 second frame");
        while (busy) @(negedge clk);
        repeat (20) @(negedge clk);
        chk("R9 select stayed low", rises - f0, 1);
        chk("R9 back-to-back count", b2b_cnt, 1);
        chk("R10 no third frame", int'(xfer_done), 0);

        // R11 R12: clearing sequence and overrun
        setup(0, 0, 0, 1, 8'd1, 4'd1, 4'd1, 4'd1);
        send(16'h1111, 16'hC0DE);
        while (xfer_done !== 1'b1) @(negedge clk);
        rd_data_en = 1'b1; @(negedge clk); rd_data_en = 1'b0;
        @(negedge clk);
        chk("R11 data read alone keeps flag", int'(xfer_done), 1);
        f0 = frames;
        send(16'h2222, 16'hD00D);
        while (frames == f0) @(negedge clk);
        @(negedge clk);
        chk("R12 overrun set", int'(overrun), 1);
        chk("R12 old data kept", rd_data, 16'hC0DE);
        void'(exp_m_q.pop_front());
        void'(exp_m_q.pop_front());
        rd_stat = 1'b1; @(negedge clk); rd_stat = 1'b0;
        rd_data_en = 1'b1; @(negedge clk); rd_data_en = 1'b0;
        chk("R11 flag cleared after sequence", int'(xfer_done), 0);
        chk("R12 overrun cleared", int'(overrun), 0);

        while (busy) @(negedge clk);
        repeat (10) @(negedge clk);
        chk("R1 slave queue drained", exp_sl_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule